// File: doc/BRIEF.md
# Two-Thread Back-End Allocation Arbiter

This block sits between two per-thread uop queues and the back-end buffers of a two-thread out-of-order core. In each cycle it picks at most one thread that may allocate resources for the uop at the head of its queue. It then hands out entry indices in the reorder buffer and, when the uop needs them, in the load buffer and the store buffer. For each buffer it keeps an occupancy count per thread. Retirement sends release pulses that return entries to the thread that owns them.

In shared mode each buffer is split into two fixed halves. If a buffer size is odd, thread 0 gets the extra entry. Threads take turns when both can allocate. A thread that cannot allocate gives its slot to the other thread. When a thread halts, the block moves to a single-thread mode, and the surviving thread may then use every entry of every buffer. An interrupt to the halted thread brings the block back to shared mode. Each mode change takes effect only once the thread whose share shrinks holds no entries.

Top module: `dual_thread_alloc_arb`

## Requirements
- R1: After reset, the mode output is 2'b00 (shared) and all counts are zero. With no uop available there is no grant. When both threads have a uop on the first cycle, thread 0 is granted.
- R2: When both threads are eligible in consecutive granted cycles, the granted thread ID alternates.
- R3: A thread that lacks room in any buffer its uop needs is skipped, and the other eligible thread is granted in the same cycle.
- R4: When only one thread has a uop, that thread is granted every cycle, as long as it has room.
- R5: In shared mode thread 0 may hold at most ceil(N/2) entries of a buffer of size N, and thread 1 at most floor(N/2). With the default sizes 126/48/32, that is 63 reorder, 24 load and 16 store entries per thread.
- R6: In shared mode thread 0 draws indices upward from 0 and thread 1 from ceil(N/2). Each thread wraps back to the bottom of its own half.
- R7: A uop is granted only if every buffer it needs has room. A refused uop consumes no entry of any buffer.
- R8: A release pulse frees one entry of that thread's buffer. A release while the count is zero is ignored.
- R9: In shared mode, a halt pulse from a thread that holds no entries (and is not granted that cycle) changes the mode. Halting thread 0 gives 2'b10 (thread 1 only). Halting thread 1 gives 2'b01 (thread 0 only). The halted thread is then never granted, and the survivor may fill each whole buffer. A halt from a thread that holds entries is ignored.
- R10: An interrupt pulse to the halted thread returns the mode to 2'b00 only if the active thread holds no entries. On that return, both threads restart at the bottom of their halves.
- R11: The turn pointer moves to the other thread after each grant and holds on cycles without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 2 | Per-thread uop available at queue head |
| uop_needs_ld | input | 2 | Per-thread head uop needs a load entry |
| uop_needs_st | input | 2 | Per-thread head uop needs a store entry |
| rel_rob | input | 2 | Per-thread reorder entry release pulse |
| rel_ld | input | 2 | Per-thread load entry release pulse |
| rel_st | input | 2 | Per-thread store entry release pulse |
| halt_req | input | 2 | Per-thread halt pulse |
| intr_req | input | 2 | Per-thread interrupt pulse (wakes a halted thread) |
| grant | output | 1 | A uop is allocated this cycle |
| grant_tid | output | 1 | Thread that receives the grant |
| grant_rob_idx | output | $clog2(ROB_TOTAL) | Reorder entry index of the grant |
| grant_ld_idx | output | $clog2(LDB_TOTAL) | Load entry index; meaningful when the uop needs one |
| grant_st_idx | output | $clog2(STB_TOTAL) | Store entry index; meaningful when the uop needs one |
| mode | output | 2 | 00 shared, 01 thread 0 only, 10 thread 1 only |

## Verification
The hardest state to reach from the ports is a single-thread mode in which the surviving thread owns entries outside its former half. This happens once thread 1's indices have wrapped past the top of the buffer into what used to be thread 0's half. The stimulus halts an empty thread 0 and fills all 126 reorder entries from thread 1, checking every index across the wrap. It then sends an interrupt while the buffer is full, which must be refused. Finally it drains the buffer, moves thread 1's pointer off its base, and confirms that the accepted interrupt puts both threads back at their partition bases.

// File: rtl/alloc_arb_pkg.sv
package alloc_arb_pkg;

   typedef enum logic [1:0] {
      MODE_SHARED  = 2'b00,
      MODE_ONLY_T0 = 2'b01,
      MODE_ONLY_T1 = 2'b10
   } alloc_mode_e;

endpackage

// File: rtl/alloc_res_track.sv
module alloc_res_track
   import alloc_arb_pkg::*;
#(
   parameter  int TOTAL = 126,
   localparam int IW    = $clog2(TOTAL),
   localparam int CW    = $clog2(TOTAL + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  alloc_mode_e           mode,
   input  logic                  go_shared,
   input  logic [1:0]            alloc,
   input  logic [1:0]            rel,
   output logic [1:0]            room,
   output logic [1:0]            empty,
   output logic [1:0][IW-1:0]    idx,
   output logic [1:0][CW-1:0]    cnt
);

   localparam int LIM0  = (TOTAL + 1) / 2;
   localparam int LIM1  = TOTAL / 2;
   localparam int BASE1 = LIM0;

   if (TOTAL < 2) begin : g_bad_total
      $error("alloc_res_track: TOTAL must be at least 2");
   end

   for (genvar t = 0; t < 2; t++) begin : g_thr
      localparam int SH_LIM  = (t == 0) ? LIM0 : LIM1;
      localparam int SH_LO   = (t == 0) ? 0 : BASE1;
      localparam int SH_HI   = (t == 0) ? LIM0 - 1 : TOTAL - 1;
      localparam int SOLO_MD = (t == 0) ? 1 : 2;

      logic [CW-1:0] cnt_q;
      logic [IW-1:0] tail_q;
      logic [CW-1:0] lim;
      logic [IW-1:0] lo, hi;
      logic          dec;

      // R5: partitioned limit in shared mode; whole buffer or nothing when solo
      always_comb begin
         if (mode == MODE_SHARED) begin
            lim = CW'(SH_LIM);
            lo  = IW'(SH_LO);
            hi  = IW'(SH_HI);
         end else begin
            lim = (mode == alloc_mode_e'(SOLO_MD)) ? CW'(TOTAL) : '0;
            lo  = '0;
            hi  = IW'(TOTAL - 1);
         end
      end

      // R8: a release against an empty count is dropped
      assign dec      = rel[t] && (cnt_q != '0);
      assign room[t]  = cnt_q < lim;
      assign empty[t] = cnt_q == '0;
      assign idx[t]   = tail_q;
      assign cnt[t]   = cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            tail_q <= IW'(SH_LO);
         end else begin
            cnt_q <= cnt_q + CW'(alloc[t]) - CW'(dec);
            // R6/R10: advance within the window, restart at base on recombination exit
            if (go_shared)
               tail_q <= IW'(SH_LO);
            else if (alloc[t])
               tail_q <= (tail_q == hi) ? lo : tail_q + IW'(1);
         end
      end
   end

endmodule

// File: rtl/alloc_pick.sv
module alloc_pick (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] elig,
   output logic       grant,
   output logic       tid
);

   logic ptr_q;

   // R2/R3: preferred thread first, otherwise the other one
   always_comb begin
      grant = 1'b0;
      tid   = ptr_q;
      if (elig[ptr_q]) begin
         grant = 1'b1;
         tid   = ptr_q;
      end else if (elig[~ptr_q]) begin
         grant = 1'b1;
         tid   = ~ptr_q;
      end
   end

   // R11: turn moves only on a grant
   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= 1'b0;
      else if (grant)
         ptr_q <= ~tid;
   end

endmodule

// File: rtl/alloc_mode_ctl.sv
module alloc_mode_ctl
   import alloc_arb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  halt_req,
   input  logic [1:0]  intr_req,
   input  logic [1:0]  quiet,
   output alloc_mode_e mode,
   output logic        go_shared
);

   alloc_mode_e mode_q, mode_d;

   // R9/R10: transitions gated by the shrinking thread being empty
   always_comb begin
      mode_d    = mode_q;
      go_shared = 1'b0;
      unique case (mode_q)
         MODE_SHARED: begin
            if (halt_req[0] && quiet[0])
               mode_d = MODE_ONLY_T1;
            else if (halt_req[1] && quiet[1])
               mode_d = MODE_ONLY_T0;
         end
         MODE_ONLY_T1: begin
            if (intr_req[0] && quiet[1]) begin
               mode_d    = MODE_SHARED;
               go_shared = 1'b1;
            end
         end
         MODE_ONLY_T0: begin
            if (intr_req[1] && quiet[0]) begin
               mode_d    = MODE_SHARED;
               go_shared = 1'b1;
            end
         end
         default: mode_d = MODE_SHARED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= MODE_SHARED;
      else
         mode_q <= mode_d;
   end

   assign mode = mode_q;

endmodule

// File: rtl/dual_thread_alloc_arb.sv
module dual_thread_alloc_arb
   import alloc_arb_pkg::*;
#(
   parameter  int ROB_TOTAL = 126,
   parameter  int LDB_TOTAL = 48,
   parameter  int STB_TOTAL = 32,
   localparam int ROB_IW    = $clog2(ROB_TOTAL),
   localparam int LDB_IW    = $clog2(LDB_TOTAL),
   localparam int STB_IW    = $clog2(STB_TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        uop_valid,
   input  logic [1:0]        uop_needs_ld,
   input  logic [1:0]        uop_needs_st,
   input  logic [1:0]        rel_rob,
   input  logic [1:0]        rel_ld,
   input  logic [1:0]        rel_st,
   input  logic [1:0]        halt_req,
   input  logic [1:0]        intr_req,
   output logic              grant,
   output logic              grant_tid,
   output logic [ROB_IW-1:0] grant_rob_idx,
   output logic [LDB_IW-1:0] grant_ld_idx,
   output logic [STB_IW-1:0] grant_st_idx,
   output logic [1:0]        mode
);

   localparam int ROB_CW = $clog2(ROB_TOTAL + 1);
   localparam int LDB_CW = $clog2(LDB_TOTAL + 1);
   localparam int STB_CW = $clog2(STB_TOTAL + 1);

   alloc_mode_e mode_e;
   logic        go_shared;
   logic [1:0]  rob_room, ld_room, st_room;
   logic [1:0]  rob_empty, ld_empty, st_empty;
   logic [1:0]  rob_alloc, ld_alloc, st_alloc;
   logic [1:0]  elig, quiet, granted_to;
   logic [1:0][ROB_IW-1:0] rob_idx;
   logic [1:0][LDB_IW-1:0] ld_idx;
   logic [1:0][STB_IW-1:0] st_idx;
   logic [1:0][ROB_CW-1:0] rob_cnt;
   logic [1:0][LDB_CW-1:0] ld_cnt;
   logic [1:0][STB_CW-1:0] st_cnt;

   // R7: eligible only with room in every buffer the uop needs
   for (genvar t = 0; t < 2; t++) begin : g_elig
      assign elig[t] = uop_valid[t] && rob_room[t]
                     && (!uop_needs_ld[t] || ld_room[t])
                     && (!uop_needs_st[t] || st_room[t]);
      assign granted_to[t] = grant && (grant_tid == 1'(t));
   end

   assign rob_alloc = granted_to;
   assign ld_alloc  = granted_to & uop_needs_ld;
   assign st_alloc  = granted_to & uop_needs_st;
   assign quiet     = rob_empty & ld_empty & st_empty & ~granted_to;

   alloc_pick i_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig),
      .grant (grant),
      .tid   (grant_tid)
   );

   alloc_mode_ctl i_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .halt_req  (halt_req),
      .intr_req  (intr_req),
      .quiet     (quiet),
      .mode      (mode_e),
      .go_shared (go_shared)
   );

   alloc_res_track #(.TOTAL(ROB_TOTAL)) i_rob (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .go_shared(go_shared),
      .alloc(rob_alloc), .rel(rel_rob), .room(rob_room), .empty(rob_empty),
      .idx(rob_idx), .cnt(rob_cnt)
   );

   alloc_res_track #(.TOTAL(LDB_TOTAL)) i_ldb (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .go_shared(go_shared),
      .alloc(ld_alloc), .rel(rel_ld), .room(ld_room), .empty(ld_empty),
      .idx(ld_idx), .cnt(ld_cnt)
   );

   alloc_res_track #(.TOTAL(STB_TOTAL)) i_stb (
      .clk(clk), .rst_n(rst_n), .mode(mode_e), .go_shared(go_shared),
      .alloc(st_alloc), .rel(rel_st), .room(st_room), .empty(st_empty),
      .idx(st_idx), .cnt(st_cnt)
   );

   assign grant_rob_idx = rob_idx[grant_tid];
   assign grant_ld_idx  = ld_idx[grant_tid];
   assign grant_st_idx  = st_idx[grant_tid];
   assign mode          = mode_e;

endmodule

// File: rtl/alloc_arb_chk.sv
module alloc_arb_chk #(
   parameter  int ROB_TOTAL = 126,
   parameter  int LDB_TOTAL = 48,
   parameter  int STB_TOTAL = 32,
   localparam int ROB_CW    = $clog2(ROB_TOTAL + 1),
   localparam int LDB_CW    = $clog2(LDB_TOTAL + 1),
   localparam int STB_CW    = $clog2(STB_TOTAL + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [1:0]             uop_valid,
   input logic [1:0]             elig,
   input logic [1:0]             rob_room,
   input logic                   grant,
   input logic                   grant_tid,
   input logic [1:0]             mode,
   input logic [1:0][ROB_CW-1:0] rob_cnt,
   input logic [1:0][LDB_CW-1:0] ld_cnt,
   input logic [1:0][STB_CW-1:0] st_cnt
);

   a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(grant) && grant && elig == 2'b11)
      |-> (grant_tid != $past(grant_tid)));

   a_r3_grant_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (uop_valid[grant_tid] && rob_room[grant_tid]));

   a_r4_lone_thread: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == 2'b01) |-> (grant && !grant_tid));

   a_r5_shared_caps: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |->
         (rob_cnt[0] <= ROB_CW'((ROB_TOTAL + 1) / 2) && rob_cnt[1] <= ROB_CW'(ROB_TOTAL / 2)
       && ld_cnt[0]  <= LDB_CW'((LDB_TOTAL + 1) / 2) && ld_cnt[1]  <= LDB_CW'(LDB_TOTAL / 2)
       && st_cnt[0]  <= STB_CW'((STB_TOTAL + 1) / 2) && st_cnt[1]  <= STB_CW'(STB_TOTAL / 2)));

   a_r9_halted_t0_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |-> !(grant && !grant_tid));

   a_r9_halted_t1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> !(grant && grant_tid));

   a_r9_halt_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 2'b00 && mode == 2'b10) |-> ($past(rob_cnt[0]) == '0));

endmodule

bind dual_thread_alloc_arb alloc_arb_chk #(
   .ROB_TOTAL(ROB_TOTAL), .LDB_TOTAL(LDB_TOTAL), .STB_TOTAL(STB_TOTAL)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .uop_valid (uop_valid),
   .elig      (elig),
   .rob_room  (rob_room),
   .grant     (grant),
   .grant_tid (grant_tid),
   .mode      (mode),
   .rob_cnt   (rob_cnt),
   .ld_cnt    (ld_cnt),
   .st_cnt    (st_cnt)
);

// File: tb/test_dual_thread_alloc_arb.sv
module test_dual_thread_alloc_arb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] uop_valid, uop_needs_ld, uop_needs_st;
   logic [1:0] rel_rob, rel_ld, rel_st, halt_req, intr_req;
   logic       grant, grant_tid;
   logic [6:0] grant_rob_idx;
   logic [5:0] grant_ld_idx;
   logic [4:0] grant_st_idx;
   logic [1:0] mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_thread_alloc_arb i_dual_thread_alloc_arb (
      .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid),
      .uop_needs_ld(uop_needs_ld), .uop_needs_st(uop_needs_st),
      .rel_rob(rel_rob), .rel_ld(rel_ld), .rel_st(rel_st),
      .halt_req(halt_req), .intr_req(intr_req),
      .grant(grant), .grant_tid(grant_tid), .grant_rob_idx(grant_rob_idx),
      .grant_ld_idx(grant_ld_idx), .grant_st_idx(grant_st_idx), .mode(mode)
   );

   // {valid, needs_ld, needs_st, exp_grant, exp_tid, exp_rob, exp_ld, exp_st}
   localparam logic [25:0] VEC [8] = '{
      {2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 7'd0,  6'd0,  5'd0 },
      {2'b11, 2'b10, 2'b00, 1'b1, 1'b1, 7'd63, 6'd24, 5'd0 },
      {2'b11, 2'b01, 2'b01, 1'b1, 1'b0, 7'd1,  6'd0,  5'd0 },
      {2'b01, 2'b00, 2'b00, 1'b1, 1'b0, 7'd2,  6'd0,  5'd0 },
      {2'b10, 2'b00, 2'b10, 1'b1, 1'b1, 7'd64, 6'd0,  5'd16},
      {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 7'd0,  6'd0,  5'd0 },
      {2'b11, 2'b00, 2'b00, 1'b1, 1'b0, 7'd3,  6'd0,  5'd0 },
      {2'b11, 2'b00, 2'b10, 1'b1, 1'b1, 7'd65, 6'd0,  5'd17}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] v, input logic [1:0] ld, input logic [1:0] st,
                        input logic [1:0] rr, input logic [1:0] rl, input logic [1:0] rs,
                        input logic [1:0] hl, input logic [1:0] it);
      @(negedge clk);
      uop_valid = v; uop_needs_ld = ld; uop_needs_st = st;
      rel_rob = rr; rel_ld = rl; rel_st = rs; halt_req = hl; intr_req = it;
      #1;
   endtask

   task automatic idle();
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      uop_valid = '0; uop_needs_ld = '0; uop_needs_st = '0;
      rel_rob = '0; rel_ld = '0; rel_st = '0; halt_req = '0; intr_req = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic expect_grant(input logic tid, input int rob, input string req);
      chk(grant === 1'b1, {req, " grant"}, int'(grant), 1);
      chk(grant_tid === tid, {req, " tid"}, int'(grant_tid), int'(tid));
      chk(int'(grant_rob_idx) == rob, {req, " rob idx"}, int'(grant_rob_idx), rob);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();

      // R1: reset state
      idle();
      chk(mode == 2'b00, "R1 mode", int'(mode), 0);
      chk(grant == 1'b0, "R1 idle grant", int'(grant), 0);

      // R2 R4 R6 R11: table walk
      for (int k = 0; k < 8; k++) begin
         logic [25:0] e;
         e = VEC[k];
         drive(e[25:24], e[23:22], e[21:20], 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
         chk(grant === e[19], $sformatf("R2 R4 R11 row %0d grant", k), int'(grant), int'(e[19]));
         if (e[19]) begin
            chk(grant_tid === e[18], $sformatf("R2 R4 row %0d tid", k), int'(grant_tid), int'(e[18]));
            chk(grant_rob_idx == e[17:11], $sformatf("R6 row %0d rob", k),
                int'(grant_rob_idx), int'(e[17:11]));
            if (e[23:22] & (2'b01 << e[18]))
               chk(grant_ld_idx == e[10:5], $sformatf("R6 row %0d ld", k),
                   int'(grant_ld_idx), int'(e[10:5]));
            if (e[21:20] & (2'b01 << e[18]))
               chk(grant_st_idx == e[4:0], $sformatf("R6 row %0d st", k),
                   int'(grant_st_idx), int'(e[4:0]));
         end
      end

      // R1: first contest after reset goes to thread 0
      do_reset();
      drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b0, 0, "R1 first pick");

      // R8 R5 R6 R3: releases on empty counts, then fill thread 0 partitions
      do_reset();
      drive(2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00);
      chk(grant == 1'b0, "R8 idle release", int'(grant), 0);
      for (int k = 0; k < 24; k++) begin
         drive(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
         chk(grant === 1'b1 && grant_tid === 1'b0, "R8 R5 load fill grant", int'(grant), 1);
         chk(int'(grant_ld_idx) == k, "R6 load idx", int'(grant_ld_idx), k);
      end
      drive(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk(grant == 1'b0, "R5 load limit", int'(grant), 0);
      drive(2'b11, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b1, 63, "R3 yield");
      for (int k = 0; k < 39; k++) begin
         drive(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
         chk(grant === 1'b1 && int'(grant_rob_idx) == 24 + k, "R4 R6 rob fill",
             int'(grant_rob_idx), 24 + k);
      end
      drive(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk(grant == 1'b0, "R5 rob limit", int'(grant), 0);
      drive(2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
      chk(grant == 1'b0, "R8 release next cycle", int'(grant), 0);
      drive(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b0, 0, "R6 wrap");

      // R7: store full blocks a load+store uop without consuming a load entry
      do_reset();
      for (int k = 0; k < 16; k++) begin
         drive(2'b10, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
         chk(grant === 1'b1 && int'(grant_st_idx) == 16 + k, "R5 R6 store fill",
             int'(grant_st_idx), 16 + k);
      end
      drive(2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk(grant == 1'b0, "R7 store full", int'(grant), 0);
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00);
      drive(2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk(grant === 1'b1, "R7 grant after release", int'(grant), 1);
      chk(grant_ld_idx == 6'd24, "R7 load untouched", int'(grant_ld_idx), 24);
      chk(grant_st_idx == 5'd16, "R7 store wrap", int'(grant_st_idx), 16);

      // R9 R10: halt thread 0, full-buffer use by thread 1, gated wake-up
      do_reset();
      drive(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b00);
      idle();
      chk(mode == 2'b00, "R9 halt refused while busy", int'(mode), 0);
      drive(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b00);
      idle();
      chk(mode == 2'b10, "R9 halt t0", int'(mode), 2);
      for (int k = 0; k < 126; k++) begin
         drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
         chk(grant === 1'b1 && grant_tid === 1'b1 && int'(grant_rob_idx) == (63 + k) % 126,
             "R9 solo fill", int'(grant_rob_idx), (63 + k) % 126);
      end
      drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk(grant == 1'b0, "R9 solo full", int'(grant), 0);
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
      idle();
      chk(mode == 2'b10, "R10 wake refused while busy", int'(mode), 2);
      for (int k = 0; k < 126; k++)
         drive(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
      for (int k = 0; k < 10; k++)
         drive(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      for (int k = 0; k < 10; k++)
         drive(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
      idle();
      chk(mode == 2'b00, "R10 wake", int'(mode), 0);
      drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b0, 0, "R10 t0 base");
      drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b1, 63, "R10 t1 base");

      // R9: halt thread 1, thread 0 then wins every cycle
      drive(2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
      drive(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00);
      idle();
      chk(mode == 2'b01, "R9 halt t1", int'(mode), 1);
      drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b0, 1, "R9 t0 solo a");
      drive(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      expect_grant(1'b0, 2, "R9 t0 solo b");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule